// File: doc/BRIEF.md
# Network DMA Area Status Sequencer

This block is the master-side sequencer of a network controller's DMA engine. It picks which memory area the engine works in during a bus tenure, requests the bus, and drives a 3-bit bus status code that names that area. Work starts from one of three requests: receive, transmit or CAM load. Receive has the highest priority and CAM load the lowest. Once the bus is granted, the block walks a fixed sequence of areas. Simple handshakes drive each step: a transfer-done pulse, a last-fragment flag, the end-of-list bit seen on the link field, the remaining buffer word count and a source-address-written pulse.

Transmit alternates between the descriptor area and the buffer area until the last-fragment flag ends it. The receive path depends on the end-of-list flag kept from the previous reception. If the flag is clear, the packet goes to the buffer area and the descriptor is then written. If the flag is set, the link field is read again first. The packet is rejected unless software has cleared end-of-list in the meantime. Descriptor updates insert idle gaps of fixed length between the field accesses. A slave register access shows idle on the status lines while it lasts. A one-cycle strobe marks the first cycle of each area transfer, and a mode input sets its polarity.

Top module: `dma_area_seq`

## Requirements
- R1: While reset is low and after it is released, with no request pending, the status is 111 (idle). In that state bus_req, pkt_reject and rsrc_req are 0 and the strobe is inactive.
- R2: A pending request raises bus_req in the next cycle, and the status stays 111 until bus_grant is seen. Receive wins over transmit, and transmit wins over CAM load. With bus_req low the status is always 111.
- R3: Transmit shows 000 (descriptor area), then 001 (buffer area) after each transfer-done. A transfer-done in the buffer area returns to 000 when tx_last is 0, and ends the tenure (status 111, bus_req 0) when tx_last is 1.
- R4: A receive with the kept end-of-list flag clear shows 010 (buffer area). After its transfer-done the status moves to 100 (descriptor area).
- R5: In the buffer area, a src_done pulse changes the status from 010 to 011 in the next cycle. It stays 011 until the area is left.
- R6: In the descriptor area, the first transfer-done (sequence-number write) is followed by exactly GAP_SL cycles of 111 (default 2) before the link access at 100. The link access's transfer-done is followed by exactly GAP_LI cycles of 111 (default 1) before the in-use write at 100.
- R7: The buffer word count is sampled at the buffer-area transfer-done. If it is below EOB_WORDS, the in-use write is followed by the resource area (101) with rsrc_req high while there. Otherwise the tenure ends after the in-use write, and an equal count does not trigger the fetch.
- R8: With the kept end-of-list flag set, a receive first rereads the link field at 100. If eol_bit is 0 at its transfer-done, the block proceeds to the buffer area (010). If eol_bit is 1, pkt_reject pulses for exactly one cycle and the block returns to idle with bus_req low. The flag is updated from eol_bit at every link-field transfer-done.
- R9: A cycle with slv_access high makes the status 111 in the next cycle and blocks any transfer-done in that cycle. Afterwards the previous code returns.
- R10: Inside one area the status code holds steady from cycle to cycle. The only changes are those listed in R5, R6 and R9.
- R11: The strobe is active for exactly the first cycle of each area transfer, and the status is valid in that cycle. With big_endian = 1 it is active low (idles high). With big_endian = 0 it is active high (idles low).
- R12: A CAM load shows 110 after the grant and ends after one transfer-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| big_endian | input | 1 | Strobe convention: 1 active-low strobe, 0 active-high strobe |
| rx_req | input | 1 | Receive work pending |
| tx_req | input | 1 | Transmit work pending |
| cam_req | input | 1 | CAM load work pending |
| bus_grant | input | 1 | Bus granted to this master |
| xfer_done | input | 1 | Current area transfer finished |
| tx_last | input | 1 | With xfer_done in the transmit buffer area: all fragments and packets sent |
| eol_bit | input | 1 | End-of-list bit of the link field, valid with xfer_done on a link access |
| src_done | input | 1 | Source address fully written in the receive buffer area |
| buf_words | input | WC_W | Remaining receive buffer word count |
| slv_access | input | 1 | Slave register access in progress |
| bus_req | output | 1 | Bus request, held for the whole tenure |
| bus_status | output | 3 | Area status code |
| addr_strb | output | 1 | Transfer-start strobe, polarity set by big_endian |
| pkt_reject | output | 1 | One-cycle pulse when the end-of-list recheck fails |
| rsrc_req | output | 1 | High while fetching a resource descriptor |

## Verification
The bench builds the block with WC_W = 8 and EOB_WORDS = 4. Counts of 3, 4 and 100 therefore land on both sides of the fetch threshold and exactly on it. The gap lengths keep their defaults of 2 and 1, so each idle gap in the descriptor sequence is checked cycle by cycle against its exact length. One receive leaves end-of-list set. This brings both the rejecting and the accepting reread paths within reach in the runs that follow.

// File: rtl/dma_seq_pkg.sv
// Shared types for the DMA area status sequencer.
// Assumes: state encodings are internal; only the 3-bit area codes are visible.
package dma_seq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WAITG,
        S_TDA,
        S_TBA,
        S_RELINK,
        S_RBA,
        S_RDA_HEAD,
        S_GAP_SL,
        S_RDA_LINK,
        S_GAP_LI,
        S_RDA_INUSE,
        S_RRA,
        S_CDA
    } seq_state_t;

    typedef enum logic [1:0] {
        J_NONE,
        J_RX,
        J_TX,
        J_CAM
    } job_t;

    localparam logic [2:0] ST_TXD     = 3'b000;
    localparam logic [2:0] ST_TXB     = 3'b001;
    localparam logic [2:0] ST_RXB     = 3'b010;
    localparam logic [2:0] ST_RXB_SRC = 3'b011;
    localparam logic [2:0] ST_RXD     = 3'b100;
    localparam logic [2:0] ST_RSRC    = 3'b101;
    localparam logic [2:0] ST_CAM     = 3'b110;
    localparam logic [2:0] ST_IDLE    = 3'b111;

    // True for states in which a memory area is being accessed.
    function automatic logic is_area(seq_state_t s);
        return !(s inside {S_IDLE, S_WAITG, S_GAP_SL, S_GAP_LI});
    endfunction

    // Maps a sequencer state to its area code; src selects the receive buffer sub-code.
    function automatic logic [2:0] area_code(seq_state_t s, logic src);
        case (s)
            S_TDA:       return ST_TXD;
            S_TBA:       return ST_TXB;
            S_RBA:       return src ? ST_RXB_SRC : ST_RXB;
            S_RELINK,
            S_RDA_HEAD,
            S_RDA_LINK,
            S_RDA_INUSE: return ST_RXD;
            S_RRA:       return ST_RSRC;
            S_CDA:       return ST_CAM;
            default:     return ST_IDLE;
        endcase
    endfunction

endpackage

// File: rtl/dma_seq_fsm.sv
// Area sequencer: arbitrates work requests, holds the bus tenure and walks
// the transmit, receive (two paths) and CAM area sequences.
// Assumes: xfer_done is a one-cycle pulse per area transfer; a slave access
// blocks progress in the cycle it is present.
module dma_seq_fsm
    import dma_seq_pkg::*;
#(
    parameter int WC_W      = 16,
    parameter int EOB_WORDS = 2,
    parameter int GAP_SL    = 2,
    parameter int GAP_LI    = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_req,
    input  logic             tx_req,
    input  logic             cam_req,
    input  logic             bus_grant,
    input  logic             xfer_done,
    input  logic             tx_last,
    input  logic             eol_bit,
    input  logic [WC_W-1:0]  buf_words,
    input  logic             slv_access,
    output seq_state_t       state_q,
    output seq_state_t       state_d,
    output logic             bus_req,
    output logic             pkt_reject,
    output logic             rsrc_req
);

    localparam int GMAX = (GAP_SL > GAP_LI) ? GAP_SL : GAP_LI;
    localparam int GW   = (GMAX > 1) ? $clog2(GMAX) : 1;
    localparam logic [GW-1:0] GLOAD_SL = GW'(GAP_SL - 1);
    localparam logic [GW-1:0] GLOAD_LI = GW'(GAP_LI - 1);
    localparam logic [WC_W-1:0] EOB_LIM = WC_W'(EOB_WORDS);

    job_t          job_q, job_d;
    logic [GW-1:0] cnt_q, cnt_d;
    logic          eol_q, eol_d;
    logic          low_q, low_d;
    logic          rej_d, rej_q;
    logic          go;

    // A transfer step only counts when no slave access is in progress.
    assign go = xfer_done && !slv_access;

    // Next-state logic for the area walk.
    always_comb begin
        state_d = state_q;
        job_d   = job_q;
        cnt_d   = cnt_q;
        eol_d   = eol_q;
        low_d   = low_q;
        rej_d   = 1'b0;
        case (state_q)
            S_IDLE: begin
                if (rx_req) begin
                    job_d   = J_RX;
                    state_d = S_WAITG;
                end else if (tx_req) begin
                    job_d   = J_TX;
                    state_d = S_WAITG;
                end else if (cam_req) begin
                    job_d   = J_CAM;
                    state_d = S_WAITG;
                end
            end
            S_WAITG: begin
                if (bus_grant) begin
                    case (job_q)
                        J_RX:    state_d = eol_q ? S_RELINK : S_RBA;
                        J_TX:    state_d = S_TDA;
                        J_CAM:   state_d = S_CDA;
                        default: state_d = S_IDLE;
                    endcase
                end
            end
            S_TDA: if (go) state_d = S_TBA;
            S_TBA: if (go) state_d = tx_last ? S_IDLE : S_TDA;
            S_RELINK: begin
                if (go) begin
                    eol_d = eol_bit;
                    if (eol_bit) begin
                        rej_d   = 1'b1;
                        state_d = S_IDLE;
                    end else begin
                        state_d = S_RBA;
                    end
                end
            end
            S_RBA: begin
                if (go) begin
                    low_d   = (buf_words < EOB_LIM);
                    state_d = S_RDA_HEAD;
                end
            end
            S_RDA_HEAD: begin
                if (go) begin
                    cnt_d   = GLOAD_SL;
                    state_d = S_GAP_SL;
                end
            end
            S_GAP_SL: begin
                if (cnt_q == '0) state_d = S_RDA_LINK;
                else             cnt_d   = cnt_q - 1'b1;
            end
            S_RDA_LINK: begin
                if (go) begin
                    eol_d   = eol_bit;
                    cnt_d   = GLOAD_LI;
                    state_d = S_GAP_LI;
                end
            end
            S_GAP_LI: begin
                if (cnt_q == '0) state_d = S_RDA_INUSE;
                else             cnt_d   = cnt_q - 1'b1;
            end
            S_RDA_INUSE: if (go) state_d = low_q ? S_RRA : S_IDLE;
            S_RRA:       if (go) state_d = S_IDLE;
            S_CDA:       if (go) state_d = S_IDLE;
            default:     state_d = S_IDLE;
        endcase
    end

    // State registers with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            job_q   <= J_NONE;
            cnt_q   <= '0;
            eol_q   <= 1'b0;
            low_q   <= 1'b0;
            rej_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            job_q   <= job_d;
            cnt_q   <= cnt_d;
            eol_q   <= eol_d;
            low_q   <= low_d;
            rej_q   <= rej_d;
        end
    end

    assign bus_req    = (state_q != S_IDLE);
    assign pkt_reject = rej_q;
    assign rsrc_req   = (state_q == S_RRA);

endmodule

// File: rtl/dma_status_enc.sv
// Status encoder: turns the sequencer state into the 3-bit area code,
// tracks the source-address sub-code and overlays idle during slave access.
// Assumes: src_done is only meaningful in the receive buffer area.
module dma_status_enc
    import dma_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  seq_state_t  state_q,
    input  seq_state_t  state_d,
    input  logic        src_done,
    input  logic        slv_access,
    output logic        slv_q,
    output logic [2:0]  bus_status
);

    logic src_q;

    // Source-address flag: set inside the buffer area, cleared on leaving it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            src_q <= 1'b0;
        else if (state_d != S_RBA)
            src_q <= 1'b0;
        else if (state_q == S_RBA && src_done && !slv_access)
            src_q <= 1'b1;
    end

    // Slave-access hold: registered so the status overlay follows the clock.
    always_ff @(posedge clk) begin
        if (!rst_n) slv_q <= 1'b0;
        else        slv_q <= slv_access;
    end

    assign bus_status = slv_q ? ST_IDLE : area_code(state_q, src_q);

endmodule

// File: rtl/dma_strobe_gen.sv
// Transfer-start strobe: one cycle on entry to each area, polarity chosen
// by the bus-mode input.
// Assumes: the mode input is static during a tenure.
module dma_strobe_gen
    import dma_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        big_endian,
    input  seq_state_t  state_q,
    input  seq_state_t  state_d,
    output logic        strb_act,
    output logic        addr_strb
);

    // Marks the first cycle of every new area transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) strb_act <= 1'b0;
        else        strb_act <= is_area(state_d) && (state_d != state_q);
    end

    assign addr_strb = big_endian ? ~strb_act : strb_act;

endmodule

// File: rtl/dma_area_seq.sv
// Top of the DMA area status sequencer: ties the area walk, the status
// encoder and the strobe generator together.
// Assumes: all inputs are synchronous to clk.
module dma_area_seq
    import dma_seq_pkg::*;
#(
    parameter int WC_W      = 16,
    parameter int EOB_WORDS = 2,
    parameter int GAP_SL    = 2,
    parameter int GAP_LI    = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            big_endian,
    input  logic            rx_req,
    input  logic            tx_req,
    input  logic            cam_req,
    input  logic            bus_grant,
    input  logic            xfer_done,
    input  logic            tx_last,
    input  logic            eol_bit,
    input  logic            src_done,
    input  logic [WC_W-1:0] buf_words,
    input  logic            slv_access,
    output logic            bus_req,
    output logic [2:0]      bus_status,
    output logic            addr_strb,
    output logic            pkt_reject,
    output logic            rsrc_req
);

    seq_state_t state_q;
    seq_state_t state_d;
    logic       slv_q;
    logic       strb_act;

    dma_seq_fsm #(
        .WC_W      (WC_W),
        .EOB_WORDS (EOB_WORDS),
        .GAP_SL    (GAP_SL),
        .GAP_LI    (GAP_LI)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_req     (rx_req),
        .tx_req     (tx_req),
        .cam_req    (cam_req),
        .bus_grant  (bus_grant),
        .xfer_done  (xfer_done),
        .tx_last    (tx_last),
        .eol_bit    (eol_bit),
        .buf_words  (buf_words),
        .slv_access (slv_access),
        .state_q    (state_q),
        .state_d    (state_d),
        .bus_req    (bus_req),
        .pkt_reject (pkt_reject),
        .rsrc_req   (rsrc_req)
    );

    dma_status_enc u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (state_q),
        .state_d    (state_d),
        .src_done   (src_done),
        .slv_access (slv_access),
        .slv_q      (slv_q),
        .bus_status (bus_status)
    );

    dma_strobe_gen u_strb (
        .clk        (clk),
        .rst_n      (rst_n),
        .big_endian (big_endian),
        .state_q    (state_q),
        .state_d    (state_d),
        .strb_act   (strb_act),
        .addr_strb  (addr_strb)
    );

endmodule

// File: rtl/dma_area_seq_chk.sv
// Property checker for the DMA area status sequencer, bound to the top.
// Assumes: rst_n is low at time zero.
module dma_area_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] status,
    input logic       bus_req,
    input logic       strb_act,
    input logic       slv_q,
    input logic       pkt_reject,
    input logic       rsrc_req
);

    // R2: without a bus tenure the status reads idle.
    p_idle_wo_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> status == 3'b111);

    // R5: the source sub-code is reached only from 010 or from a slave idle.
    p_src_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status == 3'b011) |-> ($past(status) == 3'b010 || $past(status) == 3'b111));

    // R7: the resource request goes with the resource code (or slave idle).
    p_rsrc_code_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsrc_req |-> (status == 3'b101 || status == 3'b111));

    // R8: reject is a single-cycle pulse.
    p_rej_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_reject |=> !pkt_reject);

    // R8: a reject ends the tenure.
    p_rej_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_reject |-> !bus_req);

    // R10: within an area the code holds, apart from the source sub-code step.
    p_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && $past(bus_req) && !strb_act && status != 3'b111 && $past(status) != 3'b111)
        |-> (status == $past(status) || (status == 3'b011 && $past(status) == 3'b010)));

    // R11: the strobe cycle carries a valid area code.
    p_strb_valid_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (strb_act && !slv_q) |-> (status != 3'b111 && bus_req));

endmodule

bind dma_area_seq dma_area_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .status     (bus_status),
    .bus_req    (bus_req),
    .strb_act   (strb_act),
    .slv_q      (slv_q),
    .pkt_reject (pkt_reject),
    .rsrc_req   (rsrc_req)
);

// File: tb/dma_area_seq_test.sv
// Scoreboard bench: stimulus tasks queue the expected outputs of each cycle,
// a monitor pops and compares them shortly after every rising edge.
module dma_area_seq_test;

    localparam int WC_W = 8;
    localparam int EOB  = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            big_endian = 1'b0;
    logic            rx_req = 1'b0, tx_req = 1'b0, cam_req = 1'b0;
    logic            bus_grant = 1'b0, xfer_done = 1'b0, tx_last = 1'b0;
    logic            eol_bit = 1'b0, src_done = 1'b0, slv_access = 1'b0;
    logic [WC_W-1:0] buf_words = 8'd100;
    logic            bus_req, addr_strb, pkt_reject, rsrc_req;
    logic [2:0]      bus_status;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] st;
        logic       rq;
        logic       sb;
        logic       rj;
        logic       rs;
        string      tag;
    } item_t;

    item_t exq[$];

    always #4 clk = ~clk;

    dma_area_seq #(.WC_W(WC_W), .EOB_WORDS(EOB)) uut (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .rx_req(rx_req), .tx_req(tx_req), .cam_req(cam_req),
        .bus_grant(bus_grant), .xfer_done(xfer_done), .tx_last(tx_last),
        .eol_bit(eol_bit), .src_done(src_done), .buf_words(buf_words),
        .slv_access(slv_access), .bus_req(bus_req), .bus_status(bus_status),
        .addr_strb(addr_strb), .pkt_reject(pkt_reject), .rsrc_req(rsrc_req)
    );

    // Monitor: compares the outputs after each edge with the queued expectation.
    always @(posedge clk) begin
        #2;
        if (exq.size() > 0) begin
            item_t it;
            logic  act;
            it  = exq.pop_front();
            act = big_endian ? ~addr_strb : addr_strb;
            checks++;
            if (bus_status !== it.st || bus_req !== it.rq || act !== it.sb ||
                pkt_reject !== it.rj || rsrc_req !== it.rs) begin
                errors++;
                $display("FAIL %s: got st=%b req=%b stb=%b rej=%b rsrc=%b, expected st=%b req=%b stb=%b rej=%b rsrc=%b",
                         it.tag, bus_status, bus_req, act, pkt_reject, rsrc_req,
                         it.st, it.rq, it.sb, it.rj, it.rs);
            end
        end
    end

    // Driver step: queue the expectation for the coming edge, then clear pulses.
    task automatic exp(input logic [2:0] st, input logic rq, input logic sb,
                       input logic rj, input logic rs, input string tag);
        item_t it;
        it.st = st; it.rq = rq; it.sb = sb; it.rj = rj; it.rs = rs; it.tag = tag;
        exq.push_back(it);
        @(negedge clk);
        rx_req = 0; tx_req = 0; cam_req = 0; bus_grant = 0;
        xfer_done = 0; tx_last = 0; src_done = 0; slv_access = 0;
    endtask

    // Direct check of a raw pin level.
    task automatic chk(input logic act, input logic expv, input string tag);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: got %b, expected %b", tag, act, expv);
        end
    endtask

    // Descriptor write with both gaps; eolv is the link end-of-list value.
    task automatic desc_seq(input logic eolv);
        xfer_done = 1; exp(3'b111, 1, 0, 0, 0, "R6 first gap cycle 1");
        exp(3'b111, 1, 0, 0, 0, "R6 first gap cycle 2");
        exp(3'b100, 1, 1, 0, 0, "R6 link access");
        xfer_done = 1; eol_bit = eolv; exp(3'b111, 1, 0, 0, 0, "R6 second gap");
        exp(3'b100, 1, 1, 0, 0, "R6 in-use write");
    endtask

    initial begin
        @(negedge clk);
        exp(3'b111, 0, 0, 0, 0, "R1 in reset");
        rx_req = 1; exp(3'b111, 0, 0, 0, 0, "R1 request held off in reset");
        @(negedge clk);
        rst_n = 1;
        exp(3'b111, 0, 0, 0, 0, "R1 after reset");

        // Transmit alternation.
        tx_req = 1;    exp(3'b111, 1, 0, 0, 0, "R2 request waits for grant");
        exp(3'b111, 1, 0, 0, 0, "R2 no grant yet");
        bus_grant = 1; exp(3'b000, 1, 1, 0, 0, "R3 descriptor area");
        exp(3'b000, 1, 0, 0, 0, "R10 descriptor code holds");
        xfer_done = 1; exp(3'b001, 1, 1, 0, 0, "R3 buffer area");
        xfer_done = 1; exp(3'b000, 1, 1, 0, 0, "R3 back to descriptor");
        xfer_done = 1; exp(3'b001, 1, 1, 0, 0, "R3 second fragment");
        xfer_done = 1; tx_last = 1; exp(3'b111, 0, 0, 0, 0, "R3 tenure ends");

        // CAM load in big-endian strobe mode.
        big_endian = 1;
        #1 chk(addr_strb, 1'b1, "R11 active-low strobe idles high");
        cam_req = 1;   exp(3'b111, 1, 0, 0, 0, "R2 CAM waits for grant");
        bus_grant = 1; exp(3'b110, 1, 1, 0, 0, "R12 CAM area");
        #1 chk(addr_strb, 1'b0, "R11 strobe low on entry");
        xfer_done = 1; exp(3'b111, 0, 0, 0, 0, "R12 CAM ends");
        big_endian = 0;
        #1 chk(addr_strb, 1'b0, "R11 active-high strobe idles low");

        // Priority, normal receive path with source step and slave access.
        rx_req = 1; tx_req = 1; cam_req = 1; exp(3'b111, 1, 0, 0, 0, "R2 arbitration");
        bus_grant = 1; exp(3'b010, 1, 1, 0, 0, "R2 receive wins, R4 buffer area");
        exp(3'b010, 1, 0, 0, 0, "R10 buffer code holds");
        src_done = 1;  exp(3'b011, 1, 0, 0, 0, "R5 source sub-code");
        slv_access = 1; xfer_done = 1; exp(3'b111, 1, 0, 0, 0, "R9 idle during slave access");
        exp(3'b011, 1, 0, 0, 0, "R9 code restored, done ignored");
        xfer_done = 1; buf_words = 8'd100; exp(3'b100, 1, 1, 0, 0, "R4 descriptor after buffer");
        desc_seq(1'b0);
        xfer_done = 1; exp(3'b111, 0, 0, 0, 0, "R7 no fetch with large count");

        // Normal path with depleted buffer; link leaves end-of-list set.
        rx_req = 1;    exp(3'b111, 1, 0, 0, 0, "R2 receive wait");
        bus_grant = 1; exp(3'b010, 1, 1, 0, 0, "R4 buffer area");
        xfer_done = 1; buf_words = 8'd3; exp(3'b100, 1, 1, 0, 0, "R4 descriptor area");
        desc_seq(1'b1);
        xfer_done = 1; exp(3'b101, 1, 1, 0, 1, "R7 resource fetch");
        exp(3'b101, 1, 0, 0, 1, "R7 fetch holds");
        xfer_done = 1; exp(3'b111, 0, 0, 0, 0, "R7 fetch ends");

        // Reread path, end-of-list still set: reject.
        eol_bit = 1;
        rx_req = 1;    exp(3'b111, 1, 0, 0, 0, "R8 wait");
        bus_grant = 1; exp(3'b100, 1, 1, 0, 0, "R8 link reread");
        xfer_done = 1; exp(3'b111, 0, 0, 1, 0, "R8 reject pulse");
        exp(3'b111, 0, 0, 0, 0, "R8 pulse is one cycle");

        // Reread path, software cleared end-of-list: proceed; count equals threshold.
        rx_req = 1;    exp(3'b111, 1, 0, 0, 0, "R8 wait again");
        bus_grant = 1; exp(3'b100, 1, 1, 0, 0, "R8 link reread again");
        xfer_done = 1; eol_bit = 0; exp(3'b010, 1, 1, 0, 0, "R8 proceeds to buffer");
        xfer_done = 1; buf_words = 8'd4; exp(3'b100, 1, 1, 0, 0, "R4 descriptor area");
        desc_seq(1'b0);
        xfer_done = 1; exp(3'b111, 0, 0, 0, 0, "R7 equal count no fetch");

        exp(3'b111, 0, 0, 0, 0, "R1 quiet afterwards");
        @(negedge clk);
        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(8 * 20000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule